// File: doc/BRIEF.md
# SPI Serial Memory Slave

This block behaves as a small serial EEPROM or flash device on an SPI bus, mode 0. The host drives chip select, clock and data in. The block oversamples those pins with its own system clock and assembles each selection into bytes. The first byte of a selection is an opcode. Read and page-write opcodes take a fixed number of address bytes, most significant first, and then stream data. A read returns bytes from an internal register array. A page write stores bytes into that array.

A write-enable latch gates every write, and a status opcode reports that latch. A device built as read-only can never set the latch. For a 512-byte part addressed with one byte, two extra opcodes select the upper half of the array by supplying address bit 8.

Top module: `spi_mem_slave`

## Requirements
- R1: While `spi_cs_n` is high, `spi_miso_oe` is 0 and `spi_miso` is 0. While it is low, `spi_miso_oe` is 1 and `spi_miso` changes only after a falling SCK edge, with the MSB of each byte first.
- R2: Opcode 0x03 reads. It is followed by ADDR_BYTES address bytes, MSB first. Each later byte returns the array byte at the current address on MISO, and the address then increments.
- R3: Opcode 0x02 is a page write with the same address phase. Each later byte is stored at the current address, and the address then increments. MISO is 0x00 during the write bytes.
- R4: Opcodes 0x02 and 0x0A are accepted only while the write-enable latch is set. Otherwise they are ignored: the array is unchanged, and later bytes of the selection are decoded as opcodes.
- R5: Opcode 0x06 sets the latch only when WRITABLE is 1. Opcode 0x04 always clears it.
- R6: After opcode 0x05, every following byte of the selection returns status. Status is 0x02 when the latch is set and 0x00 when it is clear.
- R7: Opcodes 0x0B (read) and 0x0A (write) start the address at 0x100 when HIGH_HALF is 1, and at 0 otherwise. The address bytes are ORed in, and the command then behaves like 0x03 or 0x02.
- R8: A data byte whose address is at or beyond MEM_BYTES does not touch the array and does not increment the address. MISO is 0x00 for such a read byte.
- R9: Raising `spi_cs_n` ends the current command, and the next selection starts in the opcode state. If any byte was stored during the selection, the latch is cleared.
- R10: Opcode 0x00 and undefined opcodes have no effect. The latch and the array are unchanged, and MISO is 0x00.
- R11: After reset, the array holds all zeros and the latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | SPI clock, idle low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | High while MISO is driven |

## Verification
Most internal faults in this block surface through MISO within a single transaction. A wrong address register shows up in the very next read byte as the wrong data. A wrong latch shows up in the next status byte. A write that should have been refused shows up when the same location is read back in the following selection. Faults in the address increment and in the upper-half base appear in streamed and high-half reads. An out-of-range write that wraps instead of stopping is caught by reading location 0.

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int MEM_BYTES  = 512,
  parameter int ADDR_BYTES = 1,
  parameter bit WRITABLE   = 1'b1,
  parameter bit HIGH_HALF  = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_cs_n,
  input  logic spi_sck,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int IW = $clog2(MEM_BYTES);
  localparam int AW = (ADDR_BYTES * 8 > IW) ? ADDR_BYTES * 8 + 1 : IW + 1;
  localparam logic [AW-1:0] MEM_END = AW'(MEM_BYTES);
  localparam logic [AW-1:0] HI_BASE = HIGH_HALF ? AW'(256) : '0;

  typedef enum logic [2:0] {S_OP, S_ADDR, S_RD, S_WR, S_STAT} st_t;

  logic [2:0] cs_s, sck_s;
  logic [1:0] mosi_s;
  logic [6:0] rx_sr;
  logic [7:0] rx_byte, tx_sr;
  logic [2:0] bit_cnt;
  logic       byte_done, load_tx, wel, wrote, wmode;
  logic [1:0] left;
  logic [AW-1:0] addr;
  st_t        state;
  logic [7:0] mem [MEM_BYTES];

  wire active   = ~cs_s[1];
  wire cs_rise  = cs_s[1] & ~cs_s[2];
  wire cs_fall  = ~cs_s[1] & cs_s[2];
  wire sck_rise = sck_s[1] & ~sck_s[2];
  wire sck_fall = ~sck_s[1] & sck_s[2];
  wire in_range = addr < MEM_END;
  wire [AW-1:0] addr_part = AW'({{(AW-8){1'b0}}, rx_byte} << (8 * (int'(left) - 1)));

  logic [7:0] tx_next;
  always_comb begin
    tx_next = 8'h00;
    if (state == S_STAT) tx_next = {6'b0, wel, 1'b0};
    else if (state == S_RD && in_range) tx_next = mem[addr[IW-1:0]];
  end

  assign spi_miso_oe = active;
  assign spi_miso    = active & tx_sr[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_s <= '1;
      sck_s <= '0;
      mosi_s <= '0;
    end else begin
      cs_s <= {cs_s[1:0], spi_cs_n};
      sck_s <= {sck_s[1:0], spi_sck};
      mosi_s <= {mosi_s[0], spi_mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_sr <= '0;
      rx_byte <= '0;
      bit_cnt <= '0;
      byte_done <= 1'b0;
      load_tx <= 1'b0;
      tx_sr <= '0;
    end else begin
      byte_done <= 1'b0;
      load_tx <= byte_done;
      if (!active) begin
        bit_cnt <= '0;
        tx_sr <= '0;
      end else if (cs_fall) begin
        bit_cnt <= '0;
        tx_sr <= '0;
      end else begin
        if (sck_rise) begin
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            rx_byte <= {rx_sr, mosi_s[1]};
            byte_done <= 1'b1;
          end else begin
            rx_sr <= {rx_sr[5:0], mosi_s[1]};
          end
        end
        if (load_tx) tx_sr <= tx_next;
        else if (sck_fall && bit_cnt != 3'd0) tx_sr <= {tx_sr[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_OP;
      addr <= '0;
      left <= '0;
      wmode <= 1'b0;
      wel <= 1'b0;
      wrote <= 1'b0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'h00;
    end else if (cs_rise) begin
      state <= S_OP;
      wrote <= 1'b0;
      if (wrote) wel <= 1'b0;
    end else if (byte_done) begin
      unique case (state)
        S_OP: begin
          case (rx_byte)
            8'h03, 8'h0B: begin
              addr <= (rx_byte == 8'h0B) ? HI_BASE : '0;
              left <= 2'(ADDR_BYTES);
              wmode <= 1'b0;
              state <= S_ADDR;
            end
            8'h02, 8'h0A: if (wel) begin
              addr <= (rx_byte == 8'h0A) ? HI_BASE : '0;
              left <= 2'(ADDR_BYTES);
              wmode <= 1'b1;
              state <= S_ADDR;
            end
            8'h06: if (WRITABLE) wel <= 1'b1;
            8'h04: wel <= 1'b0;
            8'h05: state <= S_STAT;
            default: ;
          endcase
        end
        S_ADDR: begin
          addr <= addr | addr_part;
          left <= left - 2'd1;
          if (left == 2'd1) state <= wmode ? S_WR : S_RD;
        end
        S_RD: if (in_range) addr <= addr + AW'(1);
        S_WR: if (in_range) begin
          mem[addr[IW-1:0]] <= rx_byte;
          addr <= addr + AW'(1);
          wrote <= 1'b1;
        end
        S_STAT: ;
        default: state <= S_OP;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!spi_miso && !spi_miso_oe));
  p_miso_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active) && !$past(sck_fall) && !$past(load_tx) && !$past(cs_fall)) |-> $stable(spi_miso));
  p_wel_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wel |-> WRITABLE);
  p_write_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && state == S_OP && !wel && (rx_byte == 8'h02 || rx_byte == 8'h0A) && !cs_rise) |=> state == S_OP);
  p_oob_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && !cs_rise && (state == S_RD || state == S_WR) && !in_range) |=> $stable(addr));
  p_release_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> state == S_OP);
  p_status_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_STAT && !cs_rise) |=> state == S_STAT);
endmodule

// File: tb/spi_mem_slave_test.sv
module spi_mem_slave_test;
  localparam int HALF = 6;
  localparam int NV = 14;
  // {opcode, address, third byte sent, expected MISO during third byte}
  localparam logic [31:0] VEC [NV] = '{
    32'h05_00_00_00, // R6/R11 status clear after reset
    32'h06_00_00_00, // R5 set latch, R10 trailing 0x00 opcodes
    32'h05_00_00_02, // R6 status set
    32'h02_10_A5_00, // R3 write
    32'h05_00_00_00, // R9 latch cleared after write
    32'h03_10_00_A5, // R2 read back
    32'h02_11_5A_00, // R4 write without latch
    32'h03_11_00_00, // R4 location unchanged
    32'h06_00_00_00,
    32'h0A_20_C3_00, // R7 high write
    32'h0B_20_00_C3, // R7 high read
    32'h03_20_00_00, // R7 low half untouched
    32'h3F_00_00_00, // R10 unknown opcode
    32'h05_00_00_00  // R10 latch unchanged
  };

  logic clk = 0, rst_n = 0;
  logic cs_a = 1, cs_b = 1, sck = 0, mosi = 0, sel_b = 0;
  logic miso_a, oe_a, miso_b, oe_b;
  int checks = 0, fails = 0;
  logic [7:0] q;

  always #4 clk = ~clk;

  spi_mem_slave uut (.clk(clk), .rst_n(rst_n), .spi_cs_n(cs_a), .spi_sck(sck),
    .spi_mosi(mosi), .spi_miso(miso_a), .spi_miso_oe(oe_a));
  spi_mem_slave #(.WRITABLE(1'b0), .HIGH_HALF(1'b0)) uut_ro (.clk(clk), .rst_n(rst_n),
    .spi_cs_n(cs_b), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso_b), .spi_miso_oe(oe_b));

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic sel_on();
    if (sel_b) cs_b = 0; else cs_a = 0;
    repeat (8) @(negedge clk);
  endtask

  task automatic sel_off();
    repeat (4) @(negedge clk);
    cs_a = 1; cs_b = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xb(input logic [7:0] d, output logic [7:0] r);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      repeat (HALF) @(negedge clk);
      r[i] = sel_b ? miso_b : miso_a;
      sck = 1;
      repeat (HALF) @(negedge clk);
      sck = 0;
    end
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!oe_a && !miso_a, "R1 idle", {6'b0, oe_a, miso_a}, 8'h00);

    for (int v = 0; v < NV; v++) begin
      sel_on();
      xb(VEC[v][31:24], q);
      chk(q == 8'h00, "R10 opcode byte MISO", q, 8'h00);
      xb(VEC[v][23:16], q);
      xb(VEC[v][15:8], q);
      chk(q == VEC[v][7:0], $sformatf("vector %0d R2-R10 table", v), q, VEC[v][7:0]);
      sel_off();
    end

    // R2/R3 streaming with increment
    sel_on(); xb(8'h06, q); sel_off();
    sel_on(); xb(8'h02, q); xb(8'h30, q); xb(8'h11, q); xb(8'h22, q); xb(8'h33, q); sel_off();
    sel_on(); xb(8'h03, q); xb(8'h30, q);
    xb(8'h00, q); chk(q == 8'h11, "R2 stream 0", q, 8'h11);
    chk(oe_a, "R1 oe while selected", {7'b0, oe_a}, 8'h01);
    xb(8'h00, q); chk(q == 8'h22, "R2 stream 1", q, 8'h22);
    xb(8'h00, q); chk(q == 8'h33, "R3 stream 2", q, 8'h33);
    sel_off();

    // R6 status repeats for every byte
    sel_on(); xb(8'h06, q); sel_off();
    sel_on(); xb(8'h05, q);
    for (int k = 0; k < 3; k++) begin
      xb(8'hFF, q); chk(q == 8'h02, "R6 repeated status", q, 8'h02);
    end
    sel_off();

    // R8 past the end: write 0x1FF then one byte beyond
    sel_on(); xb(8'h0A, q); xb(8'hFF, q); xb(8'hD1, q); xb(8'hE2, q); sel_off();
    sel_on(); xb(8'h0B, q); xb(8'hFF, q);
    xb(8'h00, q); chk(q == 8'hD1, "R8 last byte", q, 8'hD1);
    xb(8'h00, q); chk(q == 8'h00, "R8 beyond end reads zero", q, 8'h00);
    xb(8'h00, q); chk(q == 8'h00, "R8 no increment", q, 8'h00);
    sel_off();
    sel_on(); xb(8'h03, q); xb(8'h00, q); xb(8'h00, q);
    chk(q == 8'h00, "R8 no wrap to 0", q, 8'h00);
    sel_off();

    // R9 release mid-read: next selection decodes an opcode
    sel_on(); xb(8'h03, q); xb(8'h30, q); sel_off();
    sel_on(); xb(8'h05, q); xb(8'h00, q);
    chk(q == 8'h00, "R9 fresh opcode after release", q, 8'h00);
    sel_off();

    // R5 read-only variant ignores write enable
    sel_b = 1;
    sel_on(); xb(8'h06, q); sel_off();
    sel_on(); xb(8'h05, q); xb(8'h00, q);
    chk(q == 8'h00, "R5 read-only latch stays clear", q, 8'h00);
    sel_off();
    sel_on(); xb(8'h02, q); xb(8'h05, q); xb(8'h00, q);
    chk(q == 8'h00, "R4 write refused then 0x05 decoded", q, 8'h00);
    sel_off();
    sel_b = 0;

    // R5 disable clears latch; R11 reset clears array
    sel_on(); xb(8'h06, q); sel_off();
    sel_on(); xb(8'h04, q); sel_off();
    sel_on(); xb(8'h05, q); xb(8'h00, q);
    chk(q == 8'h00, "R5 disable", q, 8'h00);
    sel_off();
    rst_n = 0; repeat (3) @(negedge clk); rst_n = 1; repeat (3) @(negedge clk);
    sel_on(); xb(8'h03, q); xb(8'h10, q); xb(8'h00, q);
    chk(q == 8'h00, "R11 array cleared", q, 8'h00);
    sel_off();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule